// File: doc/BRIEF.md
# Page Translation Buffer with Hardware Table Walk

This block turns virtual addresses into physical addresses for 4 KiB pages. It keeps a small fully associative set of recent translations. A lookup compares the virtual page number of a request against every valid entry. On a hit, the physical address comes back combinationally in the same cycle. On a miss, a hardware walker reads one page-table entry from memory. That entry sits at a base register plus four times the virtual page number. The walker installs the entry and then retries the lookup. If the entry is marked not present, the block answers with a page fault and installs nothing.

The block keeps the referenced and dirty status of each page. Suppose an access finds the referenced bit clear, or a write finds the dirty bit clear. The block then writes the updated entry back to the page table before it responds. When a new entry must be installed, an invalid slot is used first, then a slot whose referenced bit is clear, then a slot named by a rotating pointer. A one-cycle flush empties the whole buffer.

A requester raises `req_valid` with an address and a write flag, and holds them until `resp_valid` is seen. A single word-wide memory port serves both entry reads and entry write-backs.

Top module: `tlb_refill_top`

## Requirements
- R1: A translation returns a physical address equal to the entry's physical page number concatenated with the untranslated low 12 bits of the virtual address.
- R2: A request whose page is held in a valid entry, with its referenced bit set and, for a write, its dirty bit set, is answered in the same cycle it is presented, with no memory traffic.
- R3: On a miss, the block reads the 32-bit page-table word at byte address `ptbr + 4*VPN`, where VPN is `req_vaddr[31:12]`.
- R4: Page-table word layout: bit 0 is present, bit 1 is referenced, bit 2 is dirty, and bits 31:12 hold the physical page number. Write-backs keep the page number unchanged.
- R5: If the fetched word has its present bit clear, the block responds with `resp_fault` = 1 and `resp_paddr` = 0, and installs no entry. A repeated request walks the table again.
- R6: Before the response, an access to a page whose referenced bit is clear writes the word back with present and referenced set. A write to a page whose dirty bit is clear also writes the word back with dirty set. The write-back happens once per change.
- R7: Once raised, a memory request holds its address, direction and data until `mem_ack` completes it.
- R8: A refill goes into the lowest-numbered invalid slot. If there is none, it goes into the lowest-numbered slot with its referenced bit clear. Otherwise it goes into the slot named by a rotating pointer. The pointer starts at 0 and advances by one, wrapping, each time it is used.
- R9: A flush pulse invalidates every entry in one cycle, so the next access to any page walks the table again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Invalidate all entries |
| ptbr | input | 32 | Byte address of the page table |
| req_valid | input | 1 | Translation request present |
| req_write | input | 1 | Request is a store |
| req_vaddr | input | 32 | Virtual address |
| resp_valid | output | 1 | Response in this cycle |
| resp_fault | output | 1 | Response is a page fault |
| resp_paddr | output | 32 | Physical address (0 on fault) |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Pending access is a write |
| mem_addr | output | 32 | Byte address of the page-table word |
| mem_wdata | output | 32 | Word to write back |
| mem_ack | input | 1 | Memory completes the pending access |
| mem_rdata | input | 32 | Word read, valid with `mem_ack` |

## Verification
The assertions assume that a requester keeps `req_valid`, `req_vaddr` and `req_write` steady from the request until the cycle of `resp_valid`. They also assume that `ptbr` does not change while a walk is running, that `mem_ack` arrives only while `mem_req` is high, and that flush is pulsed only when no request is outstanding. The bench issues one access at a time and releases it only after the response edge. It holds the table base constant and pulses flush between accesses. Its memory model acknowledges only pending requests, with a latency of one to three cycles that rotates from access to access.

// File: rtl/tlb_refill_pkg.sv
package tlb_refill_pkg;

  // Page-table word flag positions
  localparam int unsigned PTE_PRESENT = 0;
  localparam int unsigned PTE_REFD    = 1;
  localparam int unsigned PTE_DIRTY   = 2;

  typedef enum logic [1:0] {
    WK_LOOK  = 2'd0,
    WK_FETCH = 2'd1,
    WK_WBACK = 2'd2
  } walk_state_e;

  // An access must update the table when it would change a status bit
  function automatic logic status_stale(input logic refd_b, input logic dirty_b,
                                        input logic is_write);
    return !refd_b || (is_write && !dirty_b);
  endfunction

endpackage

// File: rtl/tlb_tag_store.sv
module tlb_tag_store #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic [VPN_W-1:0]   lookup_vpn_i,
  input  logic               fill_en_i,
  input  logic [IDX_W-1:0]   fill_idx_i,
  input  logic [VPN_W-1:0]   fill_vpn_i,
  input  logic [PPN_W-1:0]   fill_ppn_i,
  input  logic               fill_refd_i,
  input  logic               fill_dirty_i,
  input  logic               upd_en_i,
  input  logic [IDX_W-1:0]   upd_idx_i,
  input  logic               upd_dirty_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   hit_idx_o,
  output logic [PPN_W-1:0]   hit_ppn_o,
  output logic               hit_refd_o,
  output logic               hit_dirty_o,
  output logic [ENTRIES-1:0] match_o,
  output logic [ENTRIES-1:0] valid_o,
  output logic [ENTRIES-1:0] refd_o
);

  logic [PPN_W-1:0]   ppn_w [ENTRIES];
  logic [ENTRIES-1:0] dirty_w;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic             v_q, r_q, d_q;
    logic [VPN_W-1:0] tag_q;
    logic [PPN_W-1:0] pg_q;
    logic             sel_fill, sel_upd;

    assign sel_fill = fill_en_i && (fill_idx_i == IDX_W'(i));
    assign sel_upd  = upd_en_i && (upd_idx_i == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q   <= 1'b0;
        r_q   <= 1'b0;
        d_q   <= 1'b0;
        tag_q <= '0;
        pg_q  <= '0;
      end else begin
        if (flush_i)       v_q <= 1'b0;
        else if (sel_fill) v_q <= 1'b1;
        if (sel_fill) begin
          tag_q <= fill_vpn_i;
          pg_q  <= fill_ppn_i;
          r_q   <= fill_refd_i;
          d_q   <= fill_dirty_i;
        end else if (sel_upd) begin
          r_q <= 1'b1;
          d_q <= d_q | upd_dirty_i;
        end
      end
    end

    assign match_o[i] = v_q && (tag_q == lookup_vpn_i);
    assign valid_o[i] = v_q;
    assign refd_o[i]  = r_q;
    assign dirty_w[i] = d_q;
    assign ppn_w[i]   = pg_q;
  end

  always_comb begin
    hit_idx_o   = '0;
    hit_ppn_o   = '0;
    hit_refd_o  = 1'b0;
    hit_dirty_o = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_o[i]) begin
        hit_idx_o   = hit_idx_o | IDX_W'(i);
        hit_ppn_o   = hit_ppn_o | ppn_w[i];
        hit_refd_o  = hit_refd_o | refd_o[i];
        hit_dirty_o = hit_dirty_o | dirty_w[i];
      end
    end
  end

  assign hit_o = |match_o;

endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ENTRIES-1:0] refd_i,
  input  logic               take_i,
  output logic [IDX_W-1:0]   victim_o,
  output logic               use_ptr_o
);

  logic [IDX_W-1:0] ptr_q;
  logic             found_inv, found_old;
  logic [IDX_W-1:0] inv_idx, old_idx;

  always_comb begin
    found_inv = 1'b0;
    found_old = 1'b0;
    inv_idx   = '0;
    old_idx   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found_inv && !valid_i[i]) begin
        found_inv = 1'b1;
        inv_idx   = IDX_W'(i);
      end
      if (!found_old && !refd_i[i]) begin
        found_old = 1'b1;
        old_idx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    use_ptr_o = 1'b0;
    if (found_inv)      victim_o = inv_idx;
    else if (found_old) victim_o = old_idx;
    else begin
      victim_o  = ptr_q;
      use_ptr_o = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (take_i && use_ptr_o)
      ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  end

endmodule

// File: rtl/tlb_walker.sv
module tlb_walker
  import tlb_refill_pkg::*;
#(
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PPN_W = 20,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IDX_W = 4,
  localparam int unsigned PA_W = PPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [VPN_W-1:0]  req_vpn_i,
  input  logic [PA_W-1:0]   ptbr_i,
  input  logic              hit_i,
  input  logic [IDX_W-1:0]  hit_idx_i,
  input  logic [PPN_W-1:0]  hit_ppn_i,
  input  logic              hit_refd_i,
  input  logic              hit_dirty_i,
  input  logic              mem_ack_i,
  input  logic [PA_W-1:0]   mem_rdata_i,
  output logic              resp_ok_o,
  output logic              resp_fault_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [PA_W-1:0]   mem_addr_o,
  output logic [PA_W-1:0]   mem_wdata_o,
  output logic              fill_en_o,
  output logic [PPN_W-1:0]  fill_ppn_o,
  output logic              fill_refd_o,
  output logic              fill_dirty_o,
  output logic              upd_en_o,
  output logic [IDX_W-1:0]  upd_idx_o,
  output logic              upd_dirty_o
);

  function automatic logic [PA_W-1:0] pte_addr(input logic [PA_W-1:0] base,
                                               input logic [VPN_W-1:0] vpn);
    return base + (PA_W'(vpn) << 2);
  endfunction

  function automatic logic [PA_W-1:0] pack_pte(input logic [PPN_W-1:0] ppn,
                                               input logic dirty_b);
    return {ppn, {(OFF_W-3){1'b0}}, dirty_b, 1'b1, 1'b1};
  endfunction

  walk_state_e      state_q;
  logic [PA_W-1:0]  addr_q;
  logic [PA_W-1:0]  wb_pte_q;
  logic [IDX_W-1:0] wb_idx_q;
  logic             need_upd, fetch_done, pte_present;
  logic             unused_pte_bits;

  assign need_upd    = status_stale(hit_refd_i, hit_dirty_i, req_write_i);
  assign fetch_done  = (state_q == WK_FETCH) && mem_ack_i;
  assign pte_present = mem_rdata_i[PTE_PRESENT];
  assign unused_pte_bits = ^mem_rdata_i[OFF_W-1:3];

  assign resp_ok_o    = (state_q == WK_LOOK) && req_valid_i && hit_i && !need_upd;
  assign resp_fault_o = fetch_done && !pte_present;

  assign fill_en_o    = fetch_done && pte_present;
  assign fill_ppn_o   = mem_rdata_i[PA_W-1:OFF_W];
  assign fill_refd_o  = mem_rdata_i[PTE_REFD];
  assign fill_dirty_o = mem_rdata_i[PTE_DIRTY];

  assign upd_en_o     = (state_q == WK_WBACK) && mem_ack_i;
  assign upd_idx_o    = wb_idx_q;
  assign upd_dirty_o  = wb_pte_q[PTE_DIRTY];

  assign mem_req_o    = (state_q != WK_LOOK);
  assign mem_we_o     = (state_q == WK_WBACK);
  assign mem_addr_o   = addr_q;
  assign mem_wdata_o  = wb_pte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= WK_LOOK;
      addr_q   <= '0;
      wb_pte_q <= '0;
      wb_idx_q <= '0;
    end else begin
      unique case (state_q)
        WK_LOOK: begin
          if (req_valid_i && !hit_i) begin
            addr_q  <= pte_addr(ptbr_i, req_vpn_i);
            state_q <= WK_FETCH;
          end else if (req_valid_i && need_upd) begin
            addr_q   <= pte_addr(ptbr_i, req_vpn_i);
            wb_idx_q <= hit_idx_i;
            wb_pte_q <= pack_pte(hit_ppn_i, hit_dirty_i | req_write_i);
            state_q  <= WK_WBACK;
          end
        end
        WK_FETCH: if (mem_ack_i) state_q <= WK_LOOK;
        WK_WBACK: if (mem_ack_i) state_q <= WK_LOOK;
        default:  state_q <= WK_LOOK;
      endcase
    end
  end

endmodule

// File: rtl/tlb_refill_top.sv
module tlb_refill_top #(
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned ENTRIES = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic [PA_W-1:0] ptbr,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [VA_W-1:0] req_vaddr,
  output logic            resp_valid,
  output logic            resp_fault,
  output logic [PA_W-1:0] resp_paddr,
  output logic            mem_req,
  output logic            mem_we,
  output logic [PA_W-1:0] mem_addr,
  output logic [PA_W-1:0] mem_wdata,
  input  logic            mem_ack,
  input  logic [PA_W-1:0] mem_rdata
);

  localparam int unsigned VPN_W = VA_W - OFF_W;
  localparam int unsigned PPN_W = PA_W - OFF_W;
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [VPN_W-1:0]   req_vpn;
  logic               hit, hit_refd, hit_dirty;
  logic [IDX_W-1:0]   hit_idx, victim_idx, upd_idx;
  logic [PPN_W-1:0]   hit_ppn, fill_ppn;
  logic [ENTRIES-1:0] hit_vec, valid_vec, refd_vec;
  logic               fill_en, fill_refd, fill_dirty;
  logic               upd_en, upd_dirty;
  logic               resp_ok, victim_by_ptr;

  assign req_vpn = req_vaddr[VA_W-1:OFF_W];

  tlb_tag_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush),
    .lookup_vpn_i (req_vpn),
    .fill_en_i    (fill_en),
    .fill_idx_i   (victim_idx),
    .fill_vpn_i   (req_vpn),
    .fill_ppn_i   (fill_ppn),
    .fill_refd_i  (fill_refd),
    .fill_dirty_i (fill_dirty),
    .upd_en_i     (upd_en),
    .upd_idx_i    (upd_idx),
    .upd_dirty_i  (upd_dirty),
    .hit_o        (hit),
    .hit_idx_o    (hit_idx),
    .hit_ppn_o    (hit_ppn),
    .hit_refd_o   (hit_refd),
    .hit_dirty_o  (hit_dirty),
    .match_o      (hit_vec),
    .valid_o      (valid_vec),
    .refd_o       (refd_vec)
  );

  tlb_victim_pick #(.ENTRIES(ENTRIES)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_vec),
    .refd_i    (refd_vec),
    .take_i    (fill_en),
    .victim_o  (victim_idx),
    .use_ptr_o (victim_by_ptr)
  );

  tlb_walker #(.VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_walk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid),
    .req_write_i  (req_write),
    .req_vpn_i    (req_vpn),
    .ptbr_i       (ptbr),
    .hit_i        (hit),
    .hit_idx_i    (hit_idx),
    .hit_ppn_i    (hit_ppn),
    .hit_refd_i   (hit_refd),
    .hit_dirty_i  (hit_dirty),
    .mem_ack_i    (mem_ack),
    .mem_rdata_i  (mem_rdata),
    .resp_ok_o    (resp_ok),
    .resp_fault_o (resp_fault),
    .mem_req_o    (mem_req),
    .mem_we_o     (mem_we),
    .mem_addr_o   (mem_addr),
    .mem_wdata_o  (mem_wdata),
    .fill_en_o    (fill_en),
    .fill_ppn_o   (fill_ppn),
    .fill_refd_o  (fill_refd),
    .fill_dirty_o (fill_dirty),
    .upd_en_o     (upd_en),
    .upd_idx_o    (upd_idx),
    .upd_dirty_o  (upd_dirty)
  );

  assign resp_valid = resp_ok | resp_fault;
  assign resp_paddr = resp_ok ? {hit_ppn, req_vaddr[OFF_W-1:0]} : '0;

endmodule

// File: rtl/tlb_refill_checker.sv
module tlb_refill_checker #(
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned ENTRIES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic [PA_W-1:0]    ptbr,
  input logic               req_valid,
  input logic [VA_W-1:0]    req_vaddr,
  input logic               resp_valid,
  input logic               resp_fault,
  input logic [PA_W-1:0]    resp_paddr,
  input logic               mem_req,
  input logic               mem_we,
  input logic [PA_W-1:0]    mem_addr,
  input logic [PA_W-1:0]    mem_wdata,
  input logic               mem_ack,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [ENTRIES-1:0] valid_vec
);

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_fault |-> resp_paddr[OFF_W-1:0] == req_vaddr[OFF_W-1:0]); // R1

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R2

  AST_RESP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> req_valid); // R2

  AST_PTE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && req_valid |->
      mem_addr == ptbr + (PA_W'(req_vaddr[VA_W-1:OFF_W]) << 2)); // R3

  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    resp_fault |-> resp_valid && resp_paddr == '0); // R5

  AST_WBACK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[0] && mem_wdata[1]); // R6

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                            && $stable(mem_wdata)); // R7

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> valid_vec == '0); // R9

endmodule

bind tlb_refill_top tlb_refill_checker #(
  .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .ENTRIES(ENTRIES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .ptbr       (ptbr),
  .req_valid  (req_valid),
  .req_vaddr  (req_vaddr),
  .resp_valid (resp_valid),
  .resp_fault (resp_fault),
  .resp_paddr (resp_paddr),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_ack    (mem_ack),
  .hit_vec    (hit_vec),
  .valid_vec  (valid_vec)
);

// File: tb/tlb_refill_top_tb.sv
`timescale 1ns/1ps
module tlb_refill_top_tb;

  localparam logic [31:0] PTBR = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        resp_valid, resp_fault;
  logic [31:0] resp_paddr;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  bit done = 0;
  logic [31:0] last_rd_addr = '0;

  logic [31:0] pt_mem [64];

  always #5 clk = ~clk;

  tlb_refill_top u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ptbr(PTBR),
    .req_valid(req_valid), .req_write(req_write), .req_vaddr(req_vaddr),
    .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_paddr(resp_paddr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] offs(input int v);
    return 12'((v * 37 + 5) & 12'hfff);
  endfunction

  function automatic logic [31:0] exp_ppn(input int v);
    return 32'h100 + 32'(v * 3);
  endfunction

  function automatic logic [31:0] exp_pa(input int v);
    return (exp_ppn(v) << 12) | {20'd0, offs(v)};
  endfunction

  // Memory model: latency rotates 1..3 cycles
  bit          busy = 0;
  int          wait_n = 0;
  logic [31:0] hold_addr = '0;
  int          mi;

  always @(posedge clk) begin
    mi = int'((mem_addr - PTBR) >> 2);
    if (mem_req && mem_ack) begin
      chk("R7 address held until ack", mem_addr, hold_addr);
      if (mi < 0 || mi > 63) chk("R3 address inside table", mem_addr, PTBR);
      else if (mem_we) begin
        pt_mem[mi] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rd_cnt <= rd_cnt + 1;
        last_rd_addr <= mem_addr;
      end
      mem_ack <= 1'b0;
      busy    <= 1'b0;
    end else if (mem_req && !busy) begin
      busy      <= 1'b1;
      hold_addr <= mem_addr;
      wait_n    <= (rd_cnt + wr_cnt) % 3;
    end else if (busy && !mem_ack) begin
      if (wait_n == 0) begin
        mem_ack   <= 1'b1;
        mem_rdata <= (mi >= 0 && mi < 64) ? pt_mem[mi] : 32'h0;
      end else wait_n <= wait_n - 1;
    end
  end

  task automatic do_access(input int vpn, input logic wr, output logic [31:0] pa,
                           output logic flt, output int cyc, output int nrd, output int nwr);
    int rd0, wr0;
    @(negedge clk);
    rd0 = rd_cnt;
    wr0 = wr_cnt;
    req_vaddr = {vpn[19:0], offs(vpn)};
    req_write = wr;
    req_valid = 1'b1;
    cyc = 0;
    #1;
    while (!resp_valid && cyc < 300) begin
      @(negedge clk);
      #1;
      cyc++;
    end
    if (cyc >= 300) chk("R2 response arrives", 32'd0, 32'd1);
    pa  = resp_paddr;
    flt = resp_fault;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    nrd = rd_cnt - rd0;
    nwr = wr_cnt - wr0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] pa;
    logic        flt;
    int          cyc, nrd, nwr;

    for (int v = 0; v < 64; v++)
      pt_mem[v] = (v < 40) ? ((exp_ppn(v) << 12) | 32'h1) : 32'h0;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset no response", {31'd0, resp_valid}, 32'd0);
    chk("R7 reset no memory request", {31'd0, mem_req}, 32'd0);

    // Cold reads: one table read, one write-back setting referenced
    for (int v = 0; v < 16; v++) begin
      do_access(v, 1'b0, pa, flt, cyc, nrd, nwr);
      chk("R1 cold read address", pa, exp_pa(v));
      chk("R3 cold read fetch count", 32'(nrd), 32'd1);
      chk("R3 fetch address", last_rd_addr, PTBR + 32'(v * 4));
      chk("R6 referenced write-back count", 32'(nwr), 32'd1);
      chk("R4 table word after reference", pt_mem[v], (exp_ppn(v) << 12) | 32'h3);
    end

    // Warm reads: same-cycle, no memory
    for (int v = 0; v < 16; v++) begin
      do_access(v, 1'b0, pa, flt, cyc, nrd, nwr);
      chk("R2 warm read latency", 32'(cyc), 32'd0);
      chk("R2 warm read no traffic", 32'(nrd + nwr), 32'd0);
      chk("R1 warm read address", pa, exp_pa(v));
    end

    // First writes: dirty write-back only
    for (int v = 0; v < 16; v++) begin
      do_access(v, 1'b1, pa, flt, cyc, nrd, nwr);
      chk("R6 dirty write-back count", 32'(nwr), 32'd1);
      chk("R6 no fetch on write hit", 32'(nrd), 32'd0);
      chk("R4 table word after store", pt_mem[v], (exp_ppn(v) << 12) | 32'h7);
      chk("R1 store address", pa, exp_pa(v));
    end

    // Repeated writes: pure hits
    for (int v = 0; v < 16; v++) begin
      do_access(v, 1'b1, pa, flt, cyc, nrd, nwr);
      chk("R2 warm store latency", 32'(cyc), 32'd0);
      chk("R6 no second write-back", 32'(nwr), 32'd0);
    end

    // Not-present pages fault and are not installed
    for (int v = 40; v < 44; v++) begin
      do_access(v, v[0], pa, flt, cyc, nrd, nwr);
      chk("R5 fault flag", {31'd0, flt}, 32'd1);
      chk("R5 fault address zero", pa, 32'd0);
      chk("R5 fault fetch count", 32'(nrd), 32'd1);
      chk("R5 fault no write-back", 32'(nwr), 32'd0);
      do_access(v, 1'b0, pa, flt, cyc, nrd, nwr);
      chk("R5 retry walks again", 32'(nrd), 32'd1);
    end

    // Full buffer, all referenced: rotating pointer evicts slots 0..3 (pages 0..3)
    for (int v = 16; v < 20; v++) begin
      do_access(v, 1'b0, pa, flt, cyc, nrd, nwr);
      chk("R8 new page fetched", 32'(nrd), 32'd1);
      chk("R1 new page address", pa, exp_pa(v));
    end
    for (int v = 4; v < 20; v++) begin
      do_access(v, 1'b0, pa, flt, cyc, nrd, nwr);
      chk("R8 survivor still held", 32'(nrd), 32'd0);
    end
    do_access(0, 1'b0, pa, flt, cyc, nrd, nwr);
    chk("R8 evicted page refetched", 32'(nrd), 32'd1);
    chk("R6 refetched status already set", 32'(nwr), 32'd0);
    do_access(4, 1'b0, pa, flt, cyc, nrd, nwr);
    chk("R8 pointer moved to slot 4", 32'(nrd), 32'd1);
    do_access(6, 1'b0, pa, flt, cyc, nrd, nwr);
    chk("R8 slot 6 untouched", 32'(nrd), 32'd0);

    // Flush empties everything
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    do_access(6, 1'b0, pa, flt, cyc, nrd, nwr);
    chk("R9 miss after flush", 32'(nrd), 32'd1);
    chk("R1 address after flush", pa, exp_pa(6));
    do_access(6, 1'b0, pa, flt, cyc, nrd, nwr);
    chk("R9 refilled entry hits", 32'(cyc), 32'd0);

    done = 1;
    summary();
    $finish;
  end

endmodule